// File: doc/BRIEF.md
# Frame-Synced Serial DAC Write Master

This block sends 16-bit command words from a host to a serial digital-to-analog converter. The host offers a parallel word with a valid/ready handshake. The block then runs one write frame on four wires: an active-low chip select, a frame strobe, a serial clock and a serial data line. The block never interprets the bits of the word.

The serial clock is derived from the system clock. Each half-period lasts a set number of system cycles. Every minimum setup, hold and pulse time of the converter is a parameter counted in system cycles; the integrator rounds these up from nanoseconds. The serial clock idles high, so the converter samples on falling edges. Data changes only when the serial clock is high: it is loaded at acceptance and then advanced on each rising edge, most significant bit first.

The sequencer is a single state machine with these states:
- `ST_IDLE` goes to `ST_CS_LEAD` on an accepted word.
- `ST_CS_LEAD` goes to `ST_FS_LEAD` when its timer expires.
- `ST_FS_LEAD` goes to `ST_SHIFT` when its timer expires.
- `ST_SHIFT` goes to `ST_FS_TAIL` on the rising edge that follows the sixteenth falling edge. That rising edge is the update edge.
- `ST_FS_TAIL` goes to `ST_CS_TAIL` when its timer expires.
- `ST_CS_TAIL` goes to `ST_GAP` when its timer expires.
- `ST_GAP` goes back to `ST_IDLE` when its timer expires.

Top module: `dac_frame_master`

## Requirements
- R1: Out of reset and whenever `word_ready` is high, `dac_cs_n`, `dac_fs` and `dac_sclk` are all high.
- R2: A word is taken on a clock edge where `word_valid` and `word_ready` are both high. `word_ready` is low from the next cycle until the frame has ended.
- R3: `dac_cs_n` falls at least `CS_FS_CYC` cycles before `dac_fs` falls.
- R4: `dac_sclk` idles high and toggles only while `dac_cs_n` and `dac_fs` are both low. The first falling edge comes at least `FS_SCLK_CYC` cycles after `dac_fs` falls.
- R5: A frame carries exactly 16 falling edges of `dac_sclk`. Word bit 15 is on the line at the first falling edge, and bit 0 is on the line at the sixteenth.
- R6: The high and low phases of `dac_sclk` inside a frame each last at least `HALF_CYC` cycles.
- R7: `dac_sdo` changes only while `dac_sclk` is high. It is therefore stable in every cycle where `dac_sclk` is low.
- R8: `dac_fs` rises at least `FS_TAIL_CYC` cycles after the rising clock edge that follows the sixteenth falling edge.
- R9: `dac_cs_n` rises at least `CS_TAIL_CYC` cycles after `dac_fs` rises, and `dac_fs` rises only while `dac_cs_n` is low.
- R10: `dac_fs` stays high for at least `FS_HIGH_CYC` cycles between frames. `word_ready` returns only after `dac_cs_n` is high and that time has passed.
- R11: A change on `word_data` while a frame is in flight does not alter the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | Host offers a word |
| word_data | input | 16 | Command word to send |
| word_ready | output | 1 | Block can take a word |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_fs | output | 1 | Frame strobe, low during the bit phase |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdo | output | 1 | Serial data, MSB first |

## Verification
All-zero and all-one words show whether frame length and line levels are right independently of data toggling. The words 0x8001, 0xA5A5, 0x5A5A and a walking one tell apart bit order, off-by-one shifts and a lost first or last bit. Frames are sent back to back and also after idle gaps, which separates the inter-frame guard time from the idle case. After each word is taken, the host bus is driven with the inverted word, which exposes any path from the input to the frame in flight.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CS_LEAD = 3'd1,
        ST_FS_LEAD = 3'd2,
        ST_SHIFT   = 3'd3,
        ST_FS_TAIL = 3'd4,
        ST_CS_TAIL = 3'd5,
        ST_GAP     = 3'd6
    } dfm_state_t;

    function automatic int dfm_max5(int a, int b, int c, int d, int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/dfm_timer.sv
module dfm_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dfm_sclk_gen.sv
module dfm_sclk_gen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_o,
    output logic rise_o
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (cnt_q == LIM) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
    assign rise_o = run && (cnt_q == LIM) && !sclk_q;

    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sclk_o);
endmodule

// File: rtl/dfm_shifter.sv
module dfm_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         msb_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sr_q <= '0;
        else if (load)   sr_q <= din;
        else if (shift)  sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign msb_o = sr_q[W-1];
endmodule

// File: rtl/dac_frame_master.sv
module dac_frame_master #(
    parameter int WORD_W      = 16,
    parameter int HALF_CYC    = 4,
    parameter int CS_FS_CYC   = 2,
    parameter int FS_SCLK_CYC = 1,
    parameter int FS_TAIL_CYC = 2,
    parameter int CS_TAIL_CYC = 2,
    parameter int FS_HIGH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              dac_cs_n,
    output logic              dac_fs,
    output logic              dac_sclk,
    output logic              dac_sdo
);
    import dfm_pkg::*;

    localparam int MAXC = dfm_max5(CS_FS_CYC, FS_SCLK_CYC, FS_TAIL_CYC,
                                   CS_TAIL_CYC, FS_HIGH_CYC);
    localparam int TW = $clog2(MAXC + 1);
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    dfm_state_t    state_q, state_d;
    logic [BW-1:0] bit_q;
    logic          tmr_load, tmr_done, run, rise, sh_load;
    logic [TW-1:0] tmr_val;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (word_valid)                  state_d = ST_CS_LEAD;
            ST_CS_LEAD: if (tmr_done)                    state_d = ST_FS_LEAD;
            ST_FS_LEAD: if (tmr_done)                    state_d = ST_SHIFT;
            ST_SHIFT:   if (rise && bit_q == LAST_BIT)   state_d = ST_FS_TAIL;
            ST_FS_TAIL: if (tmr_done)                    state_d = ST_CS_TAIL;
            ST_CS_TAIL: if (tmr_done)                    state_d = ST_GAP;
            ST_GAP:     if (tmr_done)                    state_d = ST_IDLE;
            default:                                     state_d = ST_IDLE;
        endcase
    end

    // outputs and timer control
    always_comb begin
        word_ready = 1'b0;
        dac_cs_n   = 1'b0;
        dac_fs     = 1'b1;
        run        = 1'b0;
        sh_load    = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (state_q)
            ST_IDLE: begin
                word_ready = 1'b1;
                dac_cs_n   = 1'b1;
                sh_load    = word_valid;
                tmr_load   = word_valid;
                tmr_val    = TW'(CS_FS_CYC - 1);
            end
            ST_CS_LEAD: begin
                tmr_load = tmr_done;
                tmr_val  = TW'(FS_SCLK_CYC - 1);
            end
            ST_FS_LEAD: dac_fs = 1'b0;
            ST_SHIFT: begin
                dac_fs   = 1'b0;
                run      = 1'b1;
                tmr_load = rise && (bit_q == LAST_BIT);
                tmr_val  = TW'(FS_TAIL_CYC - 1);
            end
            ST_FS_TAIL: begin
                dac_fs   = 1'b0;
                tmr_load = tmr_done;
                tmr_val  = TW'(CS_TAIL_CYC - 1);
            end
            ST_CS_TAIL: begin
                tmr_load = tmr_done;
                tmr_val  = TW'(FS_HIGH_CYC - 1);
            end
            ST_GAP: dac_cs_n = 1'b1;
            default: dac_cs_n = 1'b1;
        endcase
    end

    // bit counter: counts rising edges inside the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bit_q <= '0;
        else if (sh_load) bit_q <= '0;
        else if (rise)    bit_q <= bit_q + 1'b1;
    end

    dfm_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_done)
    );

    dfm_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sclk_o(dac_sclk), .rise_o(rise)
    );

    dfm_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .din(word_data),
        .shift(rise), .msb_o(dac_sdo)
    );

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (dac_cs_n && dac_fs && dac_sclk));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_ready) |-> $past(word_valid));

    assert_sclk_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_sclk) |-> (!dac_cs_n && !dac_fs));

    assert_sdo_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sclk |-> $stable(dac_sdo));

    assert_fs_rise_in_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_fs) |-> !dac_cs_n);
endmodule

// File: tb/dac_frame_master_test.sv
module dac_frame_master_test;
    // minimum times in ns, converted to 8 ns cycles by rounding up
    localparam int TCK        = 8;
    localparam int MIN_CSFS   = (10 + TCK - 1) / TCK;
    localparam int MIN_FSCK   = (8  + TCK - 1) / TCK;
    localparam int MIN_HALF   = (25 + TCK - 1) / TCK;
    localparam int MIN_SETUP  = (8  + TCK - 1) / TCK;
    localparam int MIN_HOLD   = (5  + TCK - 1) / TCK;
    localparam int MIN_FSTAIL = (10 + TCK - 1) / TCK;
    localparam int MIN_CSTAIL = (10 + TCK - 1) / TCK;
    localparam int MIN_FSHIGH = (20 + TCK - 1) / TCK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_ready, dac_cs_n, dac_fs, dac_sclk, dac_sdo;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    dac_frame_master uut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .dac_cs_n(dac_cs_n), .dac_fs(dac_fs),
        .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        while (!word_ready) @(negedge clk);
        exp_q.push_back(w);
        @(negedge clk);
        word_valid = 1'b0;
        word_data  = ~w;   // R11: bus changes while frame is in flight
        chk(word_ready == 1'b0, "R2 ready low after accept", int'(word_ready), 0);
    endtask

    // DAC-side monitor, sampling between clock edges
    int cyc = 0, nfall = 0;
    int t_csfall = -1000, t_fsfall = -1000, t_fsrise = -1000, t_edge = -1000;
    int t_sdo = -1000, t_lastfall = -1000, t_d0rise = -1000;
    logic p_cs = 1'b1, p_fs = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0, p_rdy = 1'b1;
    logic [15:0] cap = '0;
    bit first_ready_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_cs && !dac_cs_n) begin
                t_csfall = cyc;
                nfall = 0;
            end
            if (p_fs && !dac_fs) begin
                chk(cyc - t_csfall >= MIN_CSFS, "R3 cs-to-fs lead", cyc - t_csfall, MIN_CSFS);
                chk(cyc - t_fsrise >= MIN_FSHIGH, "R10 fs high time", cyc - t_fsrise, MIN_FSHIGH);
                t_fsfall = cyc;
            end
            if (dac_sdo !== p_sdo) begin
                chk(dac_sclk == 1'b1, "R7 sdo moved with sclk low", int'(dac_sclk), 1);
                chk(cyc - t_lastfall >= MIN_HOLD, "R7 hold", cyc - t_lastfall, MIN_HOLD);
                t_sdo = cyc;
            end
            if (dac_sclk !== p_sclk) begin
                chk(!dac_cs_n && !dac_fs, "R4 sclk outside frame", int'({dac_cs_n, dac_fs}), 0);
                if (!dac_sclk) begin
                    if (nfall == 0)
                        chk(cyc - t_fsfall >= MIN_FSCK, "R4 fs-to-first-fall", cyc - t_fsfall, MIN_FSCK);
                    else
                        chk(cyc - t_edge >= MIN_HALF, "R6 high phase", cyc - t_edge, MIN_HALF);
                    chk(cyc - t_sdo >= MIN_SETUP, "R7 setup", cyc - t_sdo, MIN_SETUP);
                    cap = {cap[14:0], dac_sdo};
                    nfall++;
                    t_lastfall = cyc;
                end else begin
                    chk(cyc - t_edge >= MIN_HALF, "R6 low phase", cyc - t_edge, MIN_HALF);
                    if (nfall == 16 && t_d0rise < t_fsfall) t_d0rise = cyc;
                end
                t_edge = cyc;
            end
            if (!p_fs && dac_fs) begin
                chk(nfall == 16, "R5 falling edge count", nfall, 16);
                chk(cyc - t_d0rise >= MIN_FSTAIL, "R8 fs after update edge", cyc - t_d0rise, MIN_FSTAIL);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected frame", int'(cap), -1);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(cap == e, "R5 R11 word", int'(cap), int'(e));
                end
                frames++;
                t_fsrise = cyc;
            end
            if (!p_cs && dac_cs_n) begin
                chk(cyc - t_fsrise >= MIN_CSTAIL, "R9 cs after fs", cyc - t_fsrise, MIN_CSTAIL);
                chk(cyc - t_d0rise >= MIN_CSTAIL, "R9 cs after update edge", cyc - t_d0rise, MIN_CSTAIL);
            end
            if (!p_rdy && word_ready) begin
                chk(dac_cs_n == 1'b1, "R10 ready with cs low", int'(dac_cs_n), 1);
                chk(cyc - t_fsrise >= MIN_FSHIGH, "R10 ready before fs guard", cyc - t_fsrise, MIN_FSHIGH);
                chk(dac_fs && dac_sclk, "R1 idle lines", int'({dac_fs, dac_sclk}), 3);
            end
            p_cs = dac_cs_n; p_fs = dac_fs; p_sclk = dac_sclk;
            p_sdo = dac_sdo; p_rdy = word_ready;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dac_cs_n && dac_fs && dac_sclk && word_ready, "R1 reset state",
            int'({dac_cs_n, dac_fs, dac_sclk, word_ready}), 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_ready == 1'b1, "R1 ready after reset", int'(word_ready), 1);
        send(16'h0000);
        send(16'hFFFF);
        send(16'h8001);
        repeat (20) @(negedge clk);
        send(16'hA5A5);
        send(16'h5A5A);
        for (int i = 0; i < 16; i++) send(16'h0001 << i);
        repeat (10) @(negedge clk);
        send(16'h3C96);
        while (exp_q.size() != 0 || !word_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(frames == 22, "R2 frame count", frames, 22);
        chk(dac_cs_n && dac_fs && dac_sclk, "R1 final idle", int'({dac_cs_n, dac_fs, dac_sclk}), 7);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", frames, 22);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule